// File: doc/BRIEF.md
# Row-Replay Upscaling Buffer

This block holds a single square image in on-chip memory and plays it back with every row repeated, so that a downstream stage sees a vertically stretched frame. Pixels arrive as 8-bit signed values with a valid strobe. They are stored in raster order at a linear address that starts at zero and steps by one on each accepted pixel. Once the last location is filled, the frame is frozen and further pixels are dropped.

A playback trigger starts readout. Rows come out from top to bottom. Each row is sent four times in a row, with its columns in ascending order each time, before the next row begins. Every output word is 32 bits and carries the stored pixel four times side by side. The memory keeps only 8 bits per location, and the widening happens after the read. The memory read is registered, so data appears one cycle after its address. A one-cycle done pulse marks the end of playback. The stored frame then stays available for another playback until reset, which returns the block to the capture phase.

Top module: `rowrep_upscaler`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `word_valid` and `frame_done` are low. Reset returns the block to capture, and the next accepted pixel goes to address 0.
- R2: Each cycle with `pix_valid` high during capture stores `pix_in` at the next linear address, which is row*64 + column. Idle cycles between pixels are allowed.
- R3: After 4096 pixels have been accepted, `pix_valid` has no effect, and the stored frame is unchanged when it is played back.
- R4: A `play_start` pulse before the frame is complete is ignored, and `word_valid` stays low.
- R5: `play_start` sampled high on a rising edge with a complete frame and no playback running makes `word_valid` go high after the next rising edge, carrying pixel (row 0, column 0).
- R6: Every valid output word equals the stored pixel repeated four times: bits 7:0, 15:8, 23:16 and 31:24 each hold the same pixel.
- R7: Playback emits 16384 words on consecutive cycles with `word_valid` held high. Word index n carries row n/256 and column n%64. Each row appears in four back-to-back passes.
- R8: `frame_done` is high for exactly one cycle, the cycle right after the last word, and `word_valid` is low in that cycle.
- R9: A `play_start` pulse during playback has no effect on the sequence or on its length.
- R10: After playback ends, the frame is retained, and a new `play_start` replays the same 16384 words.
- R11: A reset during playback stops output at once. A fresh frame can then be captured from address 0 and played back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Signed input pixel |
| pix_valid | input | 1 | Pixel write strobe |
| play_start | input | 1 | Playback trigger |
| word_out | output | 32 | Replicated pixel word |
| word_valid | output | 1 | Output word is valid |
| frame_done | output | 1 | One-cycle end-of-playback pulse |

## Verification
The hardest conditions to reach from the ports are the ones that need the block to be in a specific phase when a control input arrives. These are a trigger while the frame is half written, a trigger in the middle of a 16384-word playback, pixels offered after the memory is full, and a reset halfway through readout. The stimulus fills the frame with random pixels and random idle gaps from a fixed seed. It fires triggers at chosen points during the fill and during playback. It then checks every one of the 16384 words against a bench model of the row-repeat order. The last frame starts with directed extreme pixel values (-128, 127, 0, -1), written after a reset that interrupts a playback.

// File: rtl/rowrep_pkg.sv
package rowrep_pkg;
  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_READY = 2'd1,
    PH_PLAY  = 2'd2
  } rowrep_phase_t;
endpackage

// File: rtl/rowrep_wr_ctrl.sv
module rowrep_wr_ctrl #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pix_valid,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              last_write
);
  logic [ADDR_W-1:0] addr_q;

  assign we         = enable && pix_valid;
  assign waddr      = addr_q;
  assign last_write = we && (addr_q == '1);

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (we)
      addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/rowrep_rd_seq.sv
module rowrep_rd_seq #(
  parameter int COL_BITS  = 6,
  parameter int ROW_BITS  = 6,
  parameter int PASS_BITS = 2,
  localparam int ADDR_W   = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              issue,
  output logic [ADDR_W-1:0] raddr,
  output logic              last
);
  logic                 busy_q;
  logic [COL_BITS-1:0]  col_q;
  logic [PASS_BITS-1:0] pass_q;
  logic [ROW_BITS-1:0]  row_q;
  logic                 col_wrap;
  logic                 pass_wrap;

  assign col_wrap  = (col_q == '1);
  assign pass_wrap = col_wrap && (pass_q == '1);
  assign last      = busy_q && pass_wrap && (row_q == '1);
  assign issue     = busy_q;
  assign raddr     = {row_q, col_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      pass_q <= '0;
      row_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        col_q  <= '0;
        pass_q <= '0;
        row_q  <= '0;
      end
    end else begin
      col_q <= col_q + 1'b1;
      if (col_wrap)
        pass_q <= pass_q + 1'b1;
      if (pass_wrap)
        row_q <= row_q + 1'b1;
      if (last)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rowrep_frame_ram.sv
module rowrep_frame_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/rowrep_upscaler.sv
module rowrep_upscaler
  import rowrep_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COL_BITS  = 6,
  parameter int ROW_BITS  = 6,
  parameter int PASS_BITS = 2,
  localparam int REPEAT   = 1 << PASS_BITS,
  localparam int ADDR_W   = ROW_BITS + COL_BITS,
  localparam int WORD_W   = PIX_W * REPEAT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [PIX_W-1:0] pix_in,
  input  logic                    pix_valid,
  input  logic                    play_start,
  output logic [WORD_W-1:0]       word_out,
  output logic                    word_valid,
  output logic                    frame_done
);
  rowrep_phase_t     phase_q;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic              last_write;
  logic              seq_start;
  logic              issue;
  logic [ADDR_W-1:0] raddr;
  logic              seq_last;
  logic [PIX_W-1:0]  rdata;
  logic              valid_q;
  logic              last_q;
  logic              done_q;

  rowrep_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .enable     (phase_q == PH_FILL),
    .pix_valid  (pix_valid),
    .we         (we),
    .waddr      (waddr),
    .last_write (last_write)
  );

  assign seq_start = play_start && (phase_q == PH_READY);

  rowrep_rd_seq #(
    .COL_BITS  (COL_BITS),
    .ROW_BITS  (ROW_BITS),
    .PASS_BITS (PASS_BITS)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (seq_start),
    .issue (issue),
    .raddr (raddr),
    .last  (seq_last)
  );

  rowrep_frame_ram #(.DATA_W(PIX_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (pix_in),
    .re    (issue),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FILL;
    end else begin
      case (phase_q)
        PH_FILL:  if (last_write) phase_q <= PH_READY;
        PH_READY: if (play_start) phase_q <= PH_PLAY;
        PH_PLAY:  if (seq_last)   phase_q <= PH_READY;
        default:  phase_q <= PH_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= issue;
      last_q  <= seq_last;
      done_q  <= last_q;
    end
  end

  genvar g;
  generate
    for (g = 0; g < REPEAT; g++) begin : g_rep
      assign word_out[g*PIX_W +: PIX_W] = rdata;
    end
  endgenerate

  assign word_valid = valid_q;
  assign frame_done = done_q;
endmodule

// File: rtl/rowrep_upscaler_chk.sv
module rowrep_upscaler_chk #(
  parameter int PIX_W     = 8,
  parameter int COL_BITS  = 6,
  parameter int ROW_BITS  = 6,
  parameter int PASS_BITS = 2,
  localparam int REPEAT   = 1 << PASS_BITS,
  localparam int WORD_W   = PIX_W * REPEAT,
  localparam int TOTAL    = 1 << (COL_BITS + ROW_BITS + PASS_BITS),
  localparam int CNT_W    = $clog2(TOTAL) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid,
  input logic              frame_done
);
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || frame_done)
      run_cnt <= '0;
    else if (word_valid)
      run_cnt <= run_cnt + 1'b1;
  end

  // R6
  repl_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_out == {REPEAT{word_out[PIX_W-1:0]}}));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !word_valid);

  // R8
  end_mark_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(word_valid) |-> frame_done);

  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (run_cnt == TOTAL[CNT_W-1:0]));

  // R7
  run_cont_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(word_valid) |=> word_valid);
endmodule

bind rowrep_upscaler rowrep_upscaler_chk #(
  .PIX_W     (PIX_W),
  .COL_BITS  (COL_BITS),
  .ROW_BITS  (ROW_BITS),
  .PASS_BITS (PASS_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_out   (word_out),
  .word_valid (word_valid),
  .frame_done (frame_done)
);

// File: tb/rowrep_upscaler_test.sv
module rowrep_upscaler_test;
  localparam int NPIX  = 4096;
  localparam int NWORD = 16384;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [7:0] pix_in = '0;
  logic              pix_valid = 1'b0;
  logic              play_start = 1'b0;
  logic [31:0]       word_out;
  logic              word_valid;
  logic              frame_done;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;
  logic [7:0] frame [NPIX];

  always #10 clk = ~clk;

  rowrep_upscaler uut (
    .clk        (clk),
    .rst        (rst),
    .pix_in     (pix_in),
    .pix_valid  (pix_valid),
    .play_start (play_start),
    .word_out   (word_out),
    .word_valid (word_valid),
    .frame_done (frame_done)
  );

  function automatic logic [31:0] exp_word(int n);
    int row, col;
    row = n / 256;
    col = n % 64;
    return {4{frame[row * 64 + col]}};
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pix_valid = 1'b0; play_start = 1'b0;
    repeat (3) @(negedge clk);
    check(!word_valid && !frame_done, "R1 outputs during reset",
          {word_valid, frame_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!word_valid && !frame_done, "R1 outputs after reset",
          {word_valid, frame_done}, 0);
  endtask

  // writes pixels [from, to); directed values override at the start
  task automatic write_range(int from, int to, bit directed);
    for (int a = from; a < to; a++) begin
      while ($urandom % 4 == 0) begin
        pix_valid = 1'b0;
        @(negedge clk);
      end
      if (directed && a < 4) begin
        case (a)
          0: frame[a] = 8'h80;
          1: frame[a] = 8'h7f;
          2: frame[a] = 8'h00;
          default: frame[a] = 8'hff;
        endcase
      end else begin
        frame[a] = 8'($urandom);
      end
      pix_in = frame[a];
      pix_valid = 1'b1;
      @(negedge clk);
    end
    pix_valid = 1'b0;
  endtask

  task automatic play_and_check(string tag, bit poke_mid);
    int bad_data, bad_valid;
    play_start = 1'b1;
    @(negedge clk);
    play_start = 1'b0;
    check(!word_valid, {"R5 no output before latency ", tag}, word_valid, 0);
    bad_data = 0; bad_valid = 0;
    for (int n = 0; n < NWORD; n++) begin
      @(negedge clk);
      if (n == 0) begin
        check(word_valid && word_out == exp_word(0),
              {"R5 first word ", tag}, word_out, exp_word(0));
        check(word_out[7:0] == word_out[15:8] && word_out[7:0] == word_out[23:16]
              && word_out[7:0] == word_out[31:24],
              {"R6 replication ", tag}, word_out, {4{word_out[7:0]}});
      end
      if (!word_valid) bad_valid++;
      if (word_out != exp_word(n)) begin
        if (bad_data < 4)
          $display("FAIL R7 %s word %0d actual=%0h expected=%0h",
                   tag, n, word_out, exp_word(n));
        bad_data++;
      end
      if (poke_mid) begin
        if (n == 3000) play_start = 1'b1;
        if (n == 3001) play_start = 1'b0;
      end
    end
    check(bad_valid == 0, {"R7 valid held for all words ", tag}, bad_valid, 0);
    check(bad_data == 0, {"R7 data/order ", tag}, bad_data, 0);
    if (poke_mid)
      check(bad_data == 0 && bad_valid == 0, "R9 mid-play trigger ignored", bad_data, 0);
    @(negedge clk);
    check(frame_done && !word_valid, {"R8 done after last word ", tag},
          {frame_done, word_valid}, 2'b10);
    @(negedge clk);
    check(!frame_done && !word_valid, {"R8 done is one cycle ", tag},
          {frame_done, word_valid}, 0);
  endtask

  initial begin
    int early;
    void'($urandom(32'd2024));
    do_reset();

    // R2 first half, R4 trigger while filling
    write_range(0, 2000, 1'b0);
    play_start = 1'b1;
    @(negedge clk);
    play_start = 1'b0;
    early = 0;
    repeat (6) begin
      @(negedge clk);
      if (word_valid) early++;
    end
    check(early == 0, "R4 early trigger ignored", early, 0);
    write_range(2000, NPIX, 1'b0);

    // R3 extra pixels after the frame is full
    for (int e = 0; e < 10; e++) begin
      pix_in = ~frame[e];
      pix_valid = 1'b1;
      @(negedge clk);
    end
    pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!word_valid, "R3 extra pixels start nothing", word_valid, 0);

    play_and_check("R2 R3 first play", 1'b1);
    repeat (5) @(negedge clk);
    pix_in = 8'h55; pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    play_and_check("R10 replay", 1'b0);

    // R11 reset during playback
    play_start = 1'b1;
    @(negedge clk);
    play_start = 1'b0;
    repeat (100) @(negedge clk);
    check(word_valid, "R11 playback running before reset", word_valid, 1);
    do_reset();
    repeat (3) @(negedge clk);
    check(!word_valid && !frame_done, "R11 output stopped after reset",
          {word_valid, frame_done}, 0);
    write_range(0, NPIX, 1'b1);
    play_and_check("R11 new frame", 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule